// File: doc/BRIEF.md
# Latched Interrupt Status Controller

This block gathers interrupt events from the receive and transmit paths of a network controller into one 8-bit status byte. It drives a single active-high interrupt line. Five of the status positions are sticky. An event sets them, and they stay set until the host writes a 1 to the same position of the acknowledge byte. The other three positions copy a live condition each cycle. These are a receive-ready level, an allocation-done level, and an exception summary. The summary merges three exception sources, and each source has its own enable bit.

The block holds two event generators of its own. The first is an 8-bit counter of discard pulses, which raises the discard bit when the count reaches all ones. The second is a comparator that raises the early-receive bit once the byte count of a frame still in progress goes above a programmable threshold. The host reaches the block through a small register bus with 16-bit words and two byte enables.

The register map uses word addresses:

| Word | Low byte (bits 7:0) | High byte (bits 15:8) |
|---|---|---|
| 0 | Status on read, acknowledge on write | Mask |
| 1 | Exception enables: bit 0 link, bit 1 rollover, bit 2 transmit error | Reads 0 |
| 2 | Early-receive threshold, low byte | Early-receive threshold, high byte |
| 3 | Discard count on read; a write with bit-0 enable clears it | Reads 0 |

The status byte is laid out as follows:

| Bit | Meaning | Kind |
|---|---|---|
| 0 | Receive ready | Level |
| 1 | Transmit done | Sticky |
| 2 | Transmit empty | Sticky |
| 3 | Allocation done | Level |
| 4 | Receive overrun | Sticky |
| 5 | Exception summary | Level |
| 6 | Early receive | Sticky |
| 7 | Discard | Sticky |

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the status byte, mask, exception enables and discard count all read 0, the threshold reads its reset parameter (default 64), and `irq_o` is low.
- R2: `irq_o` is registered. In each cycle it equals the OR over all eight bits of (status AND mask) as they stood one clock earlier. It therefore rises one cycle after an unmasked status bit sets, and falls one cycle after the last one clears.
- R3: A write with `reg_be_i[1]` to word 0 loads the mask from `wdata[15:8]`. A write with only `reg_be_i[0]` leaves the mask unchanged. Mask bit 7 always reads 0, so the discard bit can be polled but never raises the interrupt.
- R4: Sticky bits 1, 2, 4, 6 and 7 stay set until a word-0 write with `reg_be_i[0]` carries a 1 in that position. A 0 in the acknowledge byte leaves the bit as it was.
- R5: When a set event and an acknowledge reach the same sticky bit in the same cycle, the bit ends up set.
- R6: Level bits 0, 3 and 5 copy their source condition one cycle later and are not affected by acknowledge writes.
- R7: Each cycle with `disc_pulse_i` high adds one to the discard count, which stops at 0xFF. The step from 0xFE to 0xFF sets status bit 7. A word-3 write with `reg_be_i[0]` clears the count.
- R8: Status bit 7 does not change when `disc_pulse_i` is high while the count is already 0xFF.
- R9: Status bit 6 sets when `rx_active_i` is high and `rx_bytes_i` is strictly greater than the threshold. An equal count does not set it, and nothing sets it while `rx_active_i` is low.
- R10: Bit 5 is the OR of three terms, each ANDed with its own enable: `link_chg_i` with enable bit 0, `ctr_roll_i` with enable bit 1, and a transmit error with enable bit 2. A transmit error counts only when `tx_fail_i` is nonzero and `tx_ok_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 2 | Word address of the register |
| reg_wr_i | input | 1 | Write strobe |
| reg_be_i | input | 2 | Byte enables: bit 0 for the low byte, bit 1 for the high byte |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` (combinational) |
| rx_ready_i | input | 1 | Level: a received frame is waiting |
| tx_done_i | input | 1 | Pulse: a frame has been transmitted |
| tx_empty_i | input | 1 | Pulse: the transmit queue has drained |
| alloc_ok_i | input | 1 | Level: a buffer allocation has finished |
| rx_ovrn_i | input | 1 | Pulse: a received frame was dropped because of overrun |
| link_chg_i | input | 1 | Exception source: link test transition |
| ctr_roll_i | input | 1 | Exception source: statistics counter rollover |
| tx_fail_i | input | 5 | Fatal transmit reason bits: underrun, SQE error, carrier loss, late collision, excess collisions |
| tx_ok_i | input | 1 | Transmit success flag |
| rx_active_i | input | 1 | A frame is being received |
| rx_bytes_i | input | THR_W | Bytes of the current frame stored so far |
| disc_pulse_i | input | 1 | Discard event; counted once per cycle while high |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
The checker tests five properties on every cycle:
- mask bit 7 stays low;
- a sticky bit falls only in the cycle after a matching acknowledge;
- a set event always wins over a simultaneous acknowledge;
- `irq_o` follows the previous cycle's masked status, both rising and falling;
- the discard count, once at 0xFF, holds there until a clear.

Other behaviours can only be shown by the bench's scenarios:
- how the exception enables combine with the transmit-error qualification;
- the strict comparison against the threshold;
- level bits that ignore acknowledge writes;
- byte-lane selection on the mask;
- the discard bit being raised exactly on the 255th pulse and not again.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int ST_W     = 8;
   localparam int BUS_W    = 16;
   localparam int ADDR_W   = 2;
   localparam int B_RXRDY  = 0;
   localparam int B_TXDONE = 1;
   localparam int B_TXEMP  = 2;
   localparam int B_ALLOC  = 3;
   localparam int B_OVRN   = 4;
   localparam int B_EXC    = 5;
   localparam int B_ERX    = 6;
   localparam int B_DISC   = 7;
   // positions that latch and clear on write-one
   localparam logic [ST_W-1:0] STICKY_MASK = 8'hD6;
   // mask positions that can never be enabled
   localparam logic [ST_W-1:0] MASK_LOCK   = 8'h80;
   localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
   localparam logic [ADDR_W-1:0] A_EXEN = 2'd1;
   localparam logic [ADDR_W-1:0] A_THR  = 2'd2;
   localparam logic [ADDR_W-1:0] A_DCNT = 2'd3;
   typedef enum logic [1:0] {EN_LINK = 2'd0, EN_ROLL = 2'd1, EN_TXERR = 2'd2} exc_en_e;
endpackage

// File: rtl/irq_regbank.sv
module irq_regbank
   import irq_pkg::*;
#(
   parameter int THR_W   = 16,
   parameter int CNT_W   = 8,
   parameter logic [THR_W-1:0] THR_RST = THR_W'(64)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 wr_i,
   input  logic [1:0]           be_i,
   input  logic [BUS_W-1:0]     wdata_i,
   input  logic [ST_W-1:0]      status_i,
   input  logic [CNT_W-1:0]     cnt_i,
   output logic [ST_W-1:0]      mask_o,
   output logic [2:0]           en_o,
   output logic [THR_W-1:0]     thr_o,
   output logic [ST_W-1:0]      ack_o,
   output logic                 cnt_clr_o,
   output logic [BUS_W-1:0]     rdata_o
);
   logic [ST_W-1:0]  mask_q;
   logic [2:0]       en_q;
   logic [THR_W-1:0] thr_q;
   logic [THR_W-1:0] thr_wm;

   logic wr_stat, wr_exen, wr_thr, wr_dcnt;
   assign wr_stat = wr_i && (addr_i == A_STAT);
   assign wr_exen = wr_i && (addr_i == A_EXEN);
   assign wr_thr  = wr_i && (addr_i == A_THR);
   assign wr_dcnt = wr_i && (addr_i == A_DCNT);

   // per-bit write enable for the threshold, lane chosen by bit index
   for (genvar i = 0; i < THR_W; i++) begin : g_thr_wm
      assign thr_wm[i] = wr_thr && be_i[i/8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         en_q   <= '0;
         thr_q  <= THR_RST;
      end else begin
         if (wr_stat && be_i[1])
            mask_q <= wdata_i[15:8] & ~MASK_LOCK;
         if (wr_exen && be_i[0])
            en_q <= wdata_i[2:0];
         thr_q <= (thr_q & ~thr_wm) | (wdata_i[THR_W-1:0] & thr_wm);
      end
   end

   assign ack_o     = (wr_stat && be_i[0]) ? (wdata_i[7:0] & STICKY_MASK) : '0;
   assign cnt_clr_o = wr_dcnt && be_i[0];
   assign mask_o    = mask_q;
   assign en_o      = en_q;
   assign thr_o     = thr_q;

   always_comb begin
      unique case (addr_i)
         A_STAT:  rdata_o = {mask_q, status_i};
         A_EXEN:  rdata_o = {13'd0, en_q};
         A_THR:   rdata_o = BUS_W'(thr_q);
         default: rdata_o = BUS_W'(cnt_i);
      endcase
   end
endmodule

// File: rtl/irq_event_src.sv
module irq_event_src
   import irq_pkg::*;
#(
   parameter int THR_W    = 16,
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disc_pulse_i,
   input  logic              cnt_clr_i,
   output logic [CNT_W-1:0]  cnt_o,
   input  logic              rx_active_i,
   input  logic [THR_W-1:0]  rx_bytes_i,
   input  logic [THR_W-1:0]  thr_i,
   input  logic              link_chg_i,
   input  logic              ctr_roll_i,
   input  logic [4:0]        tx_fail_i,
   input  logic              tx_ok_i,
   input  logic [2:0]        en_i,
   output logic              disc_hit_o,
   output logic              erx_o,
   output logic              exc_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;
   localparam logic [CNT_W-1:0] CNT_PRE = CNT_TOP - CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            cnt_q <= '0;
         else if (cnt_clr_i)                    cnt_q <= '0;
         else if (disc_pulse_i && cnt_q != CNT_TOP) cnt_q <= cnt_q + CNT_W'(1);
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt_q <= '0;
         else if (cnt_clr_i)    cnt_q <= '0;
         else if (disc_pulse_i) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt_o      = cnt_q;
   assign disc_hit_o = disc_pulse_i && !cnt_clr_i && (cnt_q == CNT_PRE);
   assign erx_o      = rx_active_i && (rx_bytes_i > thr_i);

   logic tx_err;
   assign tx_err = (|tx_fail_i) && !tx_ok_i;
   assign exc_o  = (link_chg_i && en_i[EN_LINK])
                 | (ctr_roll_i && en_i[EN_ROLL])
                 | (tx_err     && en_i[EN_TXERR]);
endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits
   import irq_pkg::*;
#(
   parameter logic [ST_W-1:0] STICKY = STICKY_MASK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ST_W-1:0]  src_i,
   input  logic [ST_W-1:0]  ack_i,
   input  logic [ST_W-1:0]  mask_i,
   output logic [ST_W-1:0]  status_o,
   output logic             irq_o
);
   logic [ST_W-1:0] st_q;
   logic            irq_q;

   for (genvar i = 0; i < ST_W; i++) begin : g_bit
      if (STICKY[i]) begin : g_latch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[i] <= 1'b0;
            else        st_q[i] <= (st_q[i] & ~ack_i[i]) | src_i[i];
         end
      end else begin : g_level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[i] <= 1'b0;
            else        st_q[i] <= src_i[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(st_q & mask_i);
   end

   assign status_o = st_q;
   assign irq_o    = irq_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irq_pkg::*;
#(
   parameter int THR_W    = 16,
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1,
   parameter logic [THR_W-1:0] THR_RST = THR_W'(64)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr_i,
   input  logic              reg_wr_i,
   input  logic [1:0]        reg_be_i,
   input  logic [15:0]       reg_wdata_i,
   output logic [15:0]       reg_rdata_o,
   input  logic              rx_ready_i,
   input  logic              tx_done_i,
   input  logic              tx_empty_i,
   input  logic              alloc_ok_i,
   input  logic              rx_ovrn_i,
   input  logic              link_chg_i,
   input  logic              ctr_roll_i,
   input  logic [4:0]        tx_fail_i,
   input  logic              tx_ok_i,
   input  logic              rx_active_i,
   input  logic [THR_W-1:0]  rx_bytes_i,
   input  logic              disc_pulse_i,
   output logic              irq_o
);
   if (THR_W < 8 || THR_W > 16) begin : g_bad_thr
      $error("irq_status_ctrl: THR_W must lie in 8..16");
   end
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("irq_status_ctrl: CNT_W must lie in 2..16");
   end

   logic [ST_W-1:0]  mask_q;
   logic [ST_W-1:0]  status_q;
   logic [ST_W-1:0]  ack_vec;
   logic [ST_W-1:0]  src_vec;
   logic [2:0]       exc_en;
   logic [THR_W-1:0] thr;
   logic [CNT_W-1:0] disc_cnt;
   logic             cnt_clr;
   logic             disc_hit, erx_hit, exc_lvl;

   irq_regbank #(.THR_W(THR_W), .CNT_W(CNT_W), .THR_RST(THR_RST)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .addr_i(reg_addr_i), .wr_i(reg_wr_i), .be_i(reg_be_i), .wdata_i(reg_wdata_i),
      .status_i(status_q), .cnt_i(disc_cnt),
      .mask_o(mask_q), .en_o(exc_en), .thr_o(thr),
      .ack_o(ack_vec), .cnt_clr_o(cnt_clr), .rdata_o(reg_rdata_o)
   );

   irq_event_src #(.THR_W(THR_W), .CNT_W(CNT_W), .SATURATE(SATURATE)) u_evt (
      .clk(clk), .rst_n(rst_n),
      .disc_pulse_i(disc_pulse_i), .cnt_clr_i(cnt_clr), .cnt_o(disc_cnt),
      .rx_active_i(rx_active_i), .rx_bytes_i(rx_bytes_i), .thr_i(thr),
      .link_chg_i(link_chg_i), .ctr_roll_i(ctr_roll_i),
      .tx_fail_i(tx_fail_i), .tx_ok_i(tx_ok_i), .en_i(exc_en),
      .disc_hit_o(disc_hit), .erx_o(erx_hit), .exc_o(exc_lvl)
   );

   always_comb begin
      src_vec           = '0;
      src_vec[B_RXRDY]  = rx_ready_i;
      src_vec[B_TXDONE] = tx_done_i;
      src_vec[B_TXEMP]  = tx_empty_i;
      src_vec[B_ALLOC]  = alloc_ok_i;
      src_vec[B_OVRN]   = rx_ovrn_i;
      src_vec[B_EXC]    = exc_lvl;
      src_vec[B_ERX]    = erx_hit;
      src_vec[B_DISC]   = disc_hit;
   end

   irq_status_bits #(.STICKY(STICKY_MASK)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .src_i(src_vec), .ack_i(ack_vec), .mask_i(mask_q),
      .status_o(status_q), .irq_o(irq_o)
   );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
   import irq_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [ST_W-1:0]  st,
   input logic [ST_W-1:0]  mk,
   input logic [ST_W-1:0]  ack,
   input logic [ST_W-1:0]  src,
   input logic             irq,
   input logic [CNT_W-1:0] cnt,
   input logic             cnt_clr
);
   localparam logic [CNT_W-1:0] TOP = '1;

   // R3
   mask_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mk & MASK_LOCK) == '0);

   // R4
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(st) & STICKY_MASK & ~$past(ack)) & ~st) == '0));

   // R5
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((src & ack & STICKY_MASK) != '0) |=> (($past(src & ack & STICKY_MASK) & ~st) == '0));

   // R2
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st & mk) != '0) |=> irq);

   // R2
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st & mk) == '0) |=> !irq);

   if (SATURATE) begin : g_sat_chk
      // R7
      cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt == TOP && !cnt_clr) |=> (cnt == TOP));
   end
endmodule

bind irq_status_ctrl irq_status_chk #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_chk (
   .clk(clk), .rst_n(rst_n), .st(status_q), .mk(mask_q), .ack(ack_vec),
   .src(src_vec), .irq(irq_o), .cnt(disc_cnt), .cnt_clr(cnt_clr)
);

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr_i = '0;
   logic        reg_wr_i = 1'b0;
   logic [1:0]  reg_be_i = '0;
   logic [15:0] reg_wdata_i = '0;
   logic [15:0] reg_rdata_o;
   logic        rx_ready_i = 0, tx_done_i = 0, tx_empty_i = 0, alloc_ok_i = 0, rx_ovrn_i = 0;
   logic        link_chg_i = 0, ctr_roll_i = 0, tx_ok_i = 0, rx_active_i = 0, disc_pulse_i = 0;
   logic [4:0]  tx_fail_i = '0;
   logic [15:0] rx_bytes_i = '0;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   irq_status_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
      .reg_be_i(reg_be_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .rx_ready_i(rx_ready_i), .tx_done_i(tx_done_i), .tx_empty_i(tx_empty_i),
      .alloc_ok_i(alloc_ok_i), .rx_ovrn_i(rx_ovrn_i), .link_chg_i(link_chg_i),
      .ctr_roll_i(ctr_roll_i), .tx_fail_i(tx_fail_i), .tx_ok_i(tx_ok_i),
      .rx_active_i(rx_active_i), .rx_bytes_i(rx_bytes_i), .disc_pulse_i(disc_pulse_i),
      .irq_o(irq_o)
   );

   // link, roll, reason[4:0], ok, en[2:0], expected summary
   localparam logic [11:0] EXC_TBL [8] = '{
      12'h800, 12'h803, 12'h402, 12'h405, 12'h089, 12'h098, 12'h808, 12'hFEF };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      reg_addr_i = a;
      #1 d = reg_rdata_o;
   endtask

   task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
      reg_addr_i = a; reg_be_i = be; reg_wdata_i = d; reg_wr_i = 1'b1;
      @(negedge clk);
      reg_wr_i = 1'b0; reg_be_i = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, d); chk("R1 status/mask", 32'(d), 32'h0);
      rd(2'd1, d); chk("R1 enables", 32'(d), 32'h0);
      rd(2'd2, d); chk("R1 threshold", 32'(d), 32'd64);
      rd(2'd3, d); chk("R1 count", 32'(d), 32'h0);
      chk("R1 irq", 32'(irq_o), 32'h0);

      // R10 / R6 exception summary table
      for (int i = 0; i < 8; i++) begin
         logic [11:0] e;
         e = EXC_TBL[i];
         wr(2'd1, 2'b01, {13'd0, e[3:1]});
         link_chg_i = e[11]; ctr_roll_i = e[10]; tx_fail_i = e[9:5]; tx_ok_i = e[4];
         @(negedge clk);
         rd(2'd0, d);
         chk($sformatf("R10 exc entry %0d", i), 32'(d[5]), 32'(e[0]));
         link_chg_i = 0; ctr_roll_i = 0; tx_fail_i = '0; tx_ok_i = 0;
         @(negedge clk);
      end

      // R6 level bits ignore acknowledge and follow their source
      wr(2'd1, 2'b01, 16'h0001);
      link_chg_i = 1; rx_ready_i = 1; alloc_ok_i = 1;
      @(negedge clk);
      wr(2'd0, 2'b01, 16'h00FF);
      rd(2'd0, d); chk("R6 levels kept after ack", 32'(d[7:0] & 8'h29), 32'h29);
      link_chg_i = 0; rx_ready_i = 0; alloc_ok_i = 0;
      @(negedge clk);
      rd(2'd0, d); chk("R6 levels follow source", 32'(d[7:0] & 8'h29), 32'h0);

      // R4 sticky transmit-done
      tx_done_i = 1; @(negedge clk); tx_done_i = 0;
      repeat (3) @(negedge clk);
      rd(2'd0, d); chk("R4 sticky held", 32'(d[1]), 32'h1);
      wr(2'd0, 2'b01, 16'h00FD);
      rd(2'd0, d); chk("R4 zero ack keeps bit", 32'(d[1]), 32'h1);
      wr(2'd0, 2'b01, 16'h0002);
      rd(2'd0, d); chk("R4 ack clears", 32'(d[1]), 32'h0);

      // R3 mask lanes and locked bit 7
      wr(2'd0, 2'b10, 16'hFFFF);
      rd(2'd0, d); chk("R3 word mask bit7 low", 32'(d[15:8]), 32'h7F);
      wr(2'd0, 2'b01, 16'h00FF);
      rd(2'd0, d); chk("R3 low-lane keeps mask", 32'(d[15:8]), 32'h7F);
      wr(2'd0, 2'b10, 16'h0200);
      rd(2'd0, d); chk("R3 mask reload", 32'(d[15:8]), 32'h02);

      // R2 irq timing through transmit-done, mask bit 1
      tx_done_i = 1; @(negedge clk); tx_done_i = 0;
      chk("R2 irq waits one cycle", 32'(irq_o), 32'h0);
      @(negedge clk);
      chk("R2 irq high", 32'(irq_o), 32'h1);
      wr(2'd0, 2'b01, 16'h0002);
      chk("R2 irq still high after clear edge", 32'(irq_o), 32'h1);
      @(negedge clk);
      chk("R2 irq low", 32'(irq_o), 32'h0);

      // R5 set wins over simultaneous ack
      tx_empty_i = 1;
      wr(2'd0, 2'b01, 16'h0004);
      tx_empty_i = 0;
      rd(2'd0, d); chk("R5 set wins", 32'(d[2]), 32'h1);
      wr(2'd0, 2'b01, 16'h0004);

      // R9 early receive strict compare
      wr(2'd2, 2'b11, 16'd10);
      rx_active_i = 1; rx_bytes_i = 16'd10;
      @(negedge clk);
      rd(2'd0, d); chk("R9 equal no set", 32'(d[6]), 32'h0);
      rx_bytes_i = 16'd11;
      @(negedge clk);
      rd(2'd0, d); chk("R9 above sets", 32'(d[6]), 32'h1);
      rx_active_i = 0; rx_bytes_i = 16'd200;
      wr(2'd0, 2'b01, 16'h0040);
      @(negedge clk);
      rd(2'd0, d); chk("R9 idle no set", 32'(d[6]), 32'h0);
      rx_bytes_i = '0;

      // R7 / R8 discard counter
      wr(2'd0, 2'b11, 16'hFF80);
      disc_pulse_i = 1;
      repeat (254) @(negedge clk);
      disc_pulse_i = 0;
      rd(2'd3, d); chk("R7 count 254", 32'(d), 32'hFE);
      rd(2'd0, d); chk("R7 bit clear before top", 32'(d[7]), 32'h0);
      disc_pulse_i = 1; @(negedge clk); disc_pulse_i = 0;
      rd(2'd0, d); chk("R7 bit set at top", 32'(d[7]), 32'h1);
      rd(2'd3, d); chk("R7 count top", 32'(d), 32'hFF);
      @(negedge clk);
      chk("R3 discard never interrupts", 32'(irq_o), 32'h0);
      wr(2'd0, 2'b01, 16'h0080);
      disc_pulse_i = 1; repeat (3) @(negedge clk); disc_pulse_i = 0;
      rd(2'd3, d); chk("R7 saturates", 32'(d), 32'hFF);
      rd(2'd0, d); chk("R8 no re-set at top", 32'(d[7]), 32'h0);
      wr(2'd3, 2'b01, 16'h0000);
      rd(2'd3, d); chk("R7 clear", 32'(d), 32'h0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule